// File: doc/BRIEF.md
# Bang-Bang Costas Phase Controller

This block closes a first-order digital Costas loop for a zero-IF BPSK receiver. The receiver's external phase network produces sixteen phases of the incoming phasor, and two analog selectors each pick one of them. This block supplies the two 4-bit select codes. Its inputs are the sign bits of the signal channel and the error channel, taken after the comparators. These bits arrive asynchronous to the block's clock, so each one first passes through a two-flop synchroniser. The product of the two bits (an XOR) sets the direction of a free-running up/down counter that advances once per reference clock. The counter acts as the loop's digital VCO. Its upper bits are the signal-channel phase index, and the error channel's index sits a quarter turn ahead.

With an 8-bit counter, one full turn of the selector takes 256 clocks. A 6.144 MHz reference therefore gives a pull range of about ±24 kHz. When the detector output alternates at 50% duty, the selector stays in place. Other duty ratios turn it proportionally more slowly. The synchronised signal bit is the demodulated data. An optional lock flag reports whether the net drift of the counter over each 256-clock window stayed small.

Top module: `costas_phase_ctrl`

## Requirements
- R1: The signal select code is bits [7:4] of an 8-bit counter. After reset the counter is 0, so the code is 0 and only reaches 1 after sixteen forward steps.
- R2: The error select code always equals the signal select code plus 4, modulo 16.
- R3: The rotation control is the XOR of the synchronised signal bit and the synchronised error bit. A control of 0 makes the counter count up by one per clock, and a control of 1 makes it count down by one.
- R4: Each input passes two flops. A change on an input reaches the data output on the second rising edge after it is applied, and it first steers the counter on the third edge.
- R5: The counter wraps modulo 256 in both directions: 255 counts up to 0 (code 15 to 0), and 0 counts down to 255 (code 0 to 15).
- R6: A control that alternates every clock leaves the net phase unchanged. A control of 1 for three clocks in every four turns the phase backward at half the full rate.
- R7: The data output is the synchronised signal-channel bit.
- R8: The lock flag changes only at the end of each 256-clock window counted from reset. It is then set to 1 if the window's net count (ups minus downs) lies within ±8, and to 0 otherwise.
- R9: A synchronous active-high reset clears the counter, both synchronisers and the lock flag on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that drives the loop |
| rst | input | 1 | Synchronous active-high reset |
| sig_sign_in | input | 1 | Signal-channel comparator bit, asynchronous |
| err_sign_in | input | 1 | Error-channel comparator bit, asynchronous |
| sig_sel | output | 4 | Phase select code for the signal selector |
| err_sel | output | 4 | Phase select code for the error selector |
| rx_data | output | 1 | Demodulated data bit |
| locked | output | 1 | Lock indication, updated once per window |

## Verification
Two events can fall in the same clock. One is a counter wrap across the 0/255 boundary. The other is a rotation reversal, where the control flips at the very step the counter sits on a boundary. The bench provokes the reversal by holding the error input high straight out of reset. The two synchroniser stages then let two up-steps through before the first down-step, so the counter returns through 0 and wraps to 255 exactly three clocks later. The expected codes are worked out by hand and checked at that cycle. A second coincidence is a lock-window end that falls in the same cycle as the final step of the window. It is judged with duty patterns whose drift per window is exactly +8 (flag set) and exactly +16 (flag cleared).

// File: rtl/costas_pkg.sv
package costas_pkg;

  // Rotation sense of the phase selector.
  typedef enum logic {
    ROT_FWD = 1'b0,
    ROT_BWD = 1'b1
  } rot_e;

  // Bang-bang phase detector: product of two sign bits.
  function automatic rot_e phase_detect(input logic sig_b, input logic err_b);
    return (sig_b ^ err_b) ? ROT_BWD : ROT_FWD;
  endfunction

  // One step around a ring of 2**bits positions.
  function automatic int unsigned ring_step(input int unsigned val,
                                            input rot_e        dir,
                                            input int unsigned bits);
    int unsigned modulus;
    modulus = 32'd1 << bits;
    if (dir == ROT_BWD)
      return (val + modulus - 1) % modulus;
    return (val + 1) % modulus;
  endfunction

  // Fixed offset around a ring of 2**bits positions.
  function automatic int unsigned ring_offset(input int unsigned val,
                                              input int unsigned off,
                                              input int unsigned bits);
    return (val + off) % (32'd1 << bits);
  endfunction

  // Drift test of the lock detector.
  function automatic logic within_tol(input int drift, input int tol);
    return (drift <= tol) && (drift >= -tol);
  endfunction

endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end

      if (STAGES == 2) begin : g_chk
        // R4
        sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
          (!$past(rst) && !$past(rst, 2)) |-> (q_o == $past(d_i, 2)));
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/cl_nco.sv
module cl_nco
  import costas_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 4,
  parameter int ERR_OFF = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  rot_e             dir_i,
  output logic [IDX_W-1:0] sig_idx_o,
  output logic [IDX_W-1:0] err_idx_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap_up_w;
  logic             wrap_dn_w;

  // Next value of the counter.
  always_comb begin
    cnt_d = CNT_W'(ring_step(32'(cnt_q), dir_i, CNT_W));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // Boundary events, brought out for the checks.
  assign wrap_up_w = (cnt_q == CNT_TOP) && (dir_i == ROT_FWD);
  assign wrap_dn_w = (cnt_q == '0)      && (dir_i == ROT_BWD);

  assign sig_idx_o = cnt_q[CNT_W-1 -: IDX_W];
  assign err_idx_o = IDX_W'(ring_offset(32'(sig_idx_o), ERR_OFF, IDX_W));

  // R3
  fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_i == ROT_FWD && !wrap_up_w) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  bwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_i == ROT_BWD && !wrap_dn_w) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_up_w |=> (cnt_q == '0));

  // R5
  wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_dn_w |=> (cnt_q == CNT_TOP));

  // R9
  cnt_clr_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

endmodule

// File: rtl/cl_lock.sv
module cl_lock
  import costas_pkg::*;
#(
  parameter int WIN = 256,
  parameter int TOL = 8
) (
  input  logic clk,
  input  logic rst,
  input  rot_e dir_i,
  output logic locked_o
);

  localparam int WIN_W = $clog2(WIN);
  localparam int ACC_W = WIN_W + 2;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);

  logic        [WIN_W-1:0] win_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nx;
  logic                    win_end_w;
  logic                    in_tol_w;

  assign win_end_w = (win_q == WIN_LAST);

  always_comb begin
    if (dir_i == ROT_BWD) acc_nx = acc_q - ACC_W'(1);
    else                  acc_nx = acc_q + ACC_W'(1);
  end

  assign in_tol_w = within_tol(int'(acc_nx), TOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      acc_q    <= '0;
      locked_o <= 1'b0;
    end else if (win_end_w) begin
      win_q    <= '0;
      acc_q    <= '0;
      locked_o <= in_tol_w;
    end else begin
      win_q    <= win_q + 1'b1;
      acc_q    <= acc_nx;
    end
  end

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end_w |=> $stable(locked_o));

  // R9
  lock_clr_chk: assert property (@(posedge clk)
    rst |=> !locked_o);

endmodule

// File: rtl/costas_phase_ctrl.sv
module costas_phase_ctrl
  import costas_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int IDX_W       = 4,
  parameter int ERR_OFF     = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit LOCK_EN     = 1'b1,
  parameter int LOCK_WIN    = 256,
  parameter int LOCK_TOL    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_sign_in,
  input  logic             err_sign_in,
  output logic [IDX_W-1:0] sig_sel,
  output logic [IDX_W-1:0] err_sel,
  output logic             rx_data,
  output logic             locked
);

  logic sig_s;
  logic err_s;
  rot_e dir_w;

  cl_sync #(.STAGES(SYNC_STAGES)) u_sig_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sig_sign_in),
    .q_o (sig_s)
  );

  cl_sync #(.STAGES(SYNC_STAGES)) u_err_sync (
    .clk (clk),
    .rst (rst),
    .d_i (err_sign_in),
    .q_o (err_s)
  );

  assign dir_w   = phase_detect(sig_s, err_s);
  assign rx_data = sig_s;

  cl_nco #(
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W),
    .ERR_OFF (ERR_OFF)
  ) u_nco (
    .clk       (clk),
    .rst       (rst),
    .dir_i     (dir_w),
    .sig_idx_o (sig_sel),
    .err_idx_o (err_sel)
  );

  generate
    if (LOCK_EN) begin : g_lock
      cl_lock #(
        .WIN (LOCK_WIN),
        .TOL (LOCK_TOL)
      ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .dir_i    (dir_w),
        .locked_o (locked)
      );
    end else begin : g_nolock
      assign locked = 1'b0;
    end
  endgenerate

  // R1
  idx_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((sig_sel == $past(sig_sel)) ||
                     (sig_sel == $past(sig_sel) + 1'b1) ||
                     (sig_sel == $past(sig_sel) - 1'b1)));

  // R2
  err_track_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(sig_sel) |-> $stable(err_sel));

endmodule

// File: tb/costas_phase_ctrl_tb.sv
module costas_phase_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sig_in = 1'b0;
  logic       err_in = 1'b0;
  logic [3:0] sig_sel;
  logic [3:0] err_sel;
  logic       rx_data;
  logic       locked;

  int n_chk  = 0;
  int n_fail = 0;

  // Bench-side model of the counter and the two input stages.
  logic [7:0] m_cnt = '0;
  logic m1s = 0, m1e = 0, m2s = 0, m2e = 0;

  always #4 clk = ~clk;

  costas_phase_ctrl u_dut (
    .clk         (clk),
    .rst         (rst),
    .sig_sign_in (sig_in),
    .err_sign_in (err_in),
    .sig_sel     (sig_sel),
    .err_sel     (err_sel),
    .rx_data     (rx_data),
    .locked      (locked)
  );

  // Fields: sig | period | err-high count | cycles | lock expectation (2 = skip)
  localparam logic [27:0] VEC [10] = '{
    {1'b0, 7'd1,  7'd0,  11'd40,  2'd2},
    {1'b0, 7'd1,  7'd1,  11'd40,  2'd2},
    {1'b1, 7'd1,  7'd1,  11'd50,  2'd2},
    {1'b1, 7'd1,  7'd0,  11'd50,  2'd2},
    {1'b0, 7'd2,  7'd1,  11'd600, 2'd1},
    {1'b0, 7'd1,  7'd0,  11'd600, 2'd0},
    {1'b0, 7'd64, 7'd31, 11'd640, 2'd1},
    {1'b0, 7'd32, 7'd15, 11'd640, 2'd0},
    {1'b1, 7'd4,  7'd3,  11'd600, 2'd0},
    {1'b0, 7'd2,  7'd1,  11'd600, 2'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic s, input logic e);
    @(negedge clk);
    rst = r; sig_in = s; err_in = e;
    @(posedge clk);
    if (r) begin
      m_cnt = '0; m1s = 0; m1e = 0; m2s = 0; m2e = 0;
    end else begin
      m_cnt = (m2s ^ m2e) ? m_cnt - 8'd1 : m_cnt + 8'd1;
      m2s = m1s; m2e = m1e; m1s = s; m1e = e;
    end
    #2;
  endtask

  task automatic model_chk(input string tag);
    chk({tag, " R1 sig_sel"}, int'(sig_sel), int'(m_cnt[7:4]));
    chk({tag, " R2 err_sel"}, int'(err_sel), int'(4'(m_cnt[7:4] + 4'd4)));
    chk({tag, " R7 rx_data"}, int'(rx_data), int'(m2s));
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b0);
    chk("R9 reset sig_sel", int'(sig_sel), 0);
    chk("R9 reset err_sel", int'(err_sel), 4);
    chk("R9 reset locked", int'(locked), 0);
    chk("R9 reset rx_data", int'(rx_data), 0);

    // R1 code boundary at sixteen steps
    for (int i = 0; i < 15; i++) tick(1'b0, 1'b0, 1'b0);
    chk("R1 after 15 steps", int'(sig_sel), 0);
    tick(1'b0, 1'b0, 1'b0);
    chk("R1 after 16 steps", int'(sig_sel), 1);

    // R5 upward wrap
    for (int i = 0; i < 239; i++) tick(1'b0, 1'b0, 1'b0);
    chk("R5 count 255", int'(sig_sel), 15);
    chk("R2 count 255", int'(err_sel), 3);
    tick(1'b0, 1'b0, 1'b0);
    chk("R5 wrap to 0", int'(sig_sel), 0);

    // R4/R5 reversal through zero: +1,+1 pass the sync stages, then down
    for (int i = 0; i < 2; i++) tick(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b1);
    chk("R4 three edges in", int'(sig_sel), 0);
    tick(1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    chk("R5 wrap to 255", int'(sig_sel), 15);
    chk("R2 at 255 down", int'(err_sel), 3);

    // R4/R7 data latency
    tick(1'b0, 1'b1, 1'b1);
    chk("R4 data one edge", int'(rx_data), 0);
    tick(1'b0, 1'b1, 1'b1);
    chk("R7 data two edges", int'(rx_data), 1);

    // R3 R6 R8 vector walk
    for (int v = 0; v < 10; v++) begin
      logic       vs;
      int         per, dty, ncy, lk;
      vs  = VEC[v][27];
      per = int'(VEC[v][26:20]);
      dty = int'(VEC[v][19:13]);
      ncy = int'(VEC[v][12:2]);
      lk  = int'(VEC[v][1:0]);
      for (int c = 0; c < ncy; c++) tick(1'b0, vs, ((c % per) < dty));
      model_chk($sformatf("R3 R6 vec%0d", v));
      if (lk != 2) chk($sformatf("R8 vec%0d locked", v), int'(locked), lk);
    end

    // R9 mid-run reset while locked
    tick(1'b1, 1'b0, 1'b0);
    chk("R9 midrun sig_sel", int'(sig_sel), 0);
    chk("R9 midrun locked", int'(locked), 0);
    chk("R9 midrun rx_data", int'(rx_data), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule